// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block takes a CPU core from normal execution into a handler. Every cycle it looks at a pending exception (a code with a valid flag) and a pending interrupt request. It decides whether an entry happens. If one does, it produces everything the core needs to resume in the handler: the saved status word, the saved program counter and the saved stack pointer, the new status word, the handler address, and the cause registers. It also produces single-cycle strobes that tell the core to drop its load-linked reservation, leave the sleep state and clear its delay-slot marker.

The handler address depends on the kind of event. An interrupt vectors to the vector base plus 0x600. A translation-miss exception vectors to the vector base plus 0x400. A small group of severe exception codes jumps to a fixed restart address and raises the interrupt mask. Every other exception vectors to the vector base plus 0x100. The saved program counter is moved back by one instruction when the event hits a delay slot, so the branch runs again. It is moved forward by one instruction for the trap instruction.

The core may already be inside a handler, which the block bit of its status word shows. An exception that arrives then is escalated into a reset request instead of being taken. The external interrupt controller gets the current mask level from the block and returns either a vector code or "none". The core keeps its register file, so the status word, program counter, stack pointer, vector base, delay-slot marker and sleep state arrive as inputs.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When an exception and an interrupt are both pending in the same cycle, only the exception is taken. The exception cause gets its code, and the interrupt cause keeps its previous value.
- R2: When status bit 28 (block) is set and an exception arrives with a code other than 0x1E0, the block pulses `rst_req_o` for one cycle. It does not assert `done_o`, and it leaves every saved and cause output unchanged.
- R3: When status bit 28 is set, an exception with code 0x1E0 is taken as a normal entry.
- R4: When status bit 28 is set, an interrupt is ignored unless `sleep_i` is high. Every accepted entry pulses `sleep_clr_o`.
- R5: `ic_level_o` always equals status bits 7:4. An interrupt whose controller answer has `ic_vec_valid` low causes no entry.
- R6: On entry, the saved status equals the status input, the saved PC equals the PC input, and the saved stack pointer equals the R15 input. The new status is the input with bits 30 (privilege), 29 (bank) and 28 (block) set. `lock_inval_o` pulses.
- R7: When `dslot_i` is high at entry, the saved PC is the PC input minus 2 and `dslot_clr_o` pulses.
- R8: Exception codes 0x000, 0x020 and 0x140 clear status bit 15 (FPU disable), set status bits 7:4 to 0xF, and load the PC with 0xA0000000.
- R9: Exception codes 0x040 and 0x060 load the PC with the vector base plus 0x400. Any other taken exception loads the vector base plus 0x100.
- R10: Exception code 0x160 (trap) adds 2 to the saved PC, on top of any delay-slot correction.
- R11: A taken exception writes its code to `exc_cause_o`. A taken interrupt writes the controller vector to `irq_cause_o` and loads the PC with the vector base plus 0x600.
- R12: The outputs update at the clock edge that samples the request. `done_o` is high for exactly the following cycle.
- R13: While `dslot_i` is high, an interrupt is not accepted, but an exception is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_valid | input | 1 | Exception pending |
| exc_code | input | 12 | Code of the pending exception |
| irq_req | input | 1 | Interrupt pending |
| ic_level_o | output | 4 | Current mask level sent to the interrupt controller |
| ic_vec_valid | input | 1 | Controller has an unmasked vector |
| ic_vec | input | 12 | Vector code from the controller |
| sr_i | input | 32 | Current status word |
| pc_i | input | 32 | PC of the interrupted instruction |
| r15_i | input | 32 | Current stack pointer |
| vbase_i | input | 32 | Vector base address |
| dslot_i | input | 1 | Current instruction sits in a delay slot |
| sleep_i | input | 1 | Core is in sleep state |
| done_o | output | 1 | Entry completed (one-cycle pulse) |
| rst_req_o | output | 1 | Reset request (one-cycle pulse) |
| sr_o | output | 32 | New status word |
| pc_o | output | 32 | Handler address |
| saved_sr_o | output | 32 | Saved status word |
| saved_pc_o | output | 32 | Saved PC |
| saved_sp_o | output | 32 | Saved stack pointer |
| exc_cause_o | output | 12 | Last taken exception code |
| irq_cause_o | output | 12 | Last taken interrupt vector |
| lock_inval_o | output | 1 | Drop load-linked reservation (pulse) |
| dslot_clr_o | output | 1 | Clear delay-slot marker (pulse) |
| sleep_clr_o | output | 1 | Leave sleep state (pulse) |

## Verification
The hardest situations to reach are those where several gating conditions stack up. Examples are a blocked status with sleep either set or clear, a delay slot combined with an interrupt, the one exempt code while blocked, and a trap that also sits in a delay slot. Each directed task sets the core-side inputs (status word, delay-slot marker, sleep) at a falling edge, pulses the request for one cycle, and reads the outputs at the next falling edge. Cases where nothing is accepted are checked through `done_o`, `rst_req_o` and the saved outputs, which must keep their earlier values.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int W_DATA = 32;
    localparam int W_CODE = 12;
    localparam int W_MASK = 4;

    localparam int BIT_BLOCK = 28;
    localparam int BIT_BANK  = 29;
    localparam int BIT_PRIV  = 30;
    localparam int BIT_FPDIS = 15;
    localparam int MASK_LO   = 4;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_EXC   = 2'd1,
        ACT_IRQ   = 2'd2,
        ACT_RESET = 2'd3
    } act_e;

    typedef struct packed {
        logic [W_DATA-1:0] sr;
        logic [W_DATA-1:0] pc;
        logic [W_DATA-1:0] saved_sr;
        logic [W_DATA-1:0] saved_pc;
        logic [W_DATA-1:0] saved_sp;
        logic [W_CODE-1:0] exc_cause;
        logic [W_CODE-1:0] irq_cause;
        logic              done;
        logic              rst_req;
        logic              lock_inval;
        logic              dslot_clr;
        logic              sleep_clr;
    } entry_state_t;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter logic [W_CODE-1:0] UNBLOCKED_CODE = 12'h1E0
) (
    input  logic              exc_valid,
    input  logic [W_CODE-1:0] exc_code,
    input  logic              irq_req,
    input  logic              ic_vec_valid,
    input  logic              blocked,
    input  logic              sleeping,
    input  logic              in_dslot,
    output act_e              act
);
    logic irq_allowed;

    // an interrupt needs: no delay slot, and either unblocked or waking from sleep
    assign irq_allowed = irq_req && !in_dslot && (!blocked || sleeping) && ic_vec_valid;

    always_comb begin
        act = ACT_NONE;
        if (exc_valid) begin
            if (blocked && (exc_code != UNBLOCKED_CODE)) begin
                act = ACT_RESET;
            end else begin
                act = ACT_EXC;
            end
        end else if (irq_allowed) begin
            act = ACT_IRQ;
        end
    end
endmodule

// File: rtl/exc_target.sv
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int                    N_RST      = 3,
    parameter logic [N_RST*W_CODE-1:0] RST_CODES = {12'h140, 12'h020, 12'h000},
    parameter int                    N_TLB      = 2,
    parameter logic [N_TLB*W_CODE-1:0] TLB_CODES = {12'h060, 12'h040},
    parameter logic [W_CODE-1:0]     TRAP_CODE  = 12'h160,
    parameter logic [W_DATA-1:0]     RESET_PC   = 32'hA000_0000,
    parameter logic [W_DATA-1:0]     OFS_GEN    = 32'h0000_0100,
    parameter logic [W_DATA-1:0]     OFS_TLB    = 32'h0000_0400,
    parameter logic [W_DATA-1:0]     OFS_IRQ    = 32'h0000_0600,
    parameter logic [W_DATA-1:0]     SLOT_STEP  = 32'd2
) (
    input  act_e              act,
    input  logic [W_CODE-1:0] code,
    input  logic [W_DATA-1:0] sr,
    input  logic [W_DATA-1:0] pc,
    input  logic [W_DATA-1:0] vbase,
    input  logic              dslot,
    output logic [W_DATA-1:0] sr_nx,
    output logic [W_DATA-1:0] pc_nx,
    output logic [W_DATA-1:0] spc_nx
);
    localparam logic [W_DATA-1:0] MODE_SET =
        (W_DATA'(1) << BIT_BLOCK) | (W_DATA'(1) << BIT_BANK) | (W_DATA'(1) << BIT_PRIV);

    logic [N_RST-1:0] rst_hit;
    logic [N_TLB-1:0] tlb_hit;
    logic             is_exc;
    logic             is_rst_class;
    logic             is_tlb_class;
    logic             is_trap;

    genvar gi;
    generate
        for (gi = 0; gi < N_RST; gi++) begin : g_rst
            assign rst_hit[gi] = (code == RST_CODES[gi*W_CODE +: W_CODE]);
        end
        for (gi = 0; gi < N_TLB; gi++) begin : g_tlb
            assign tlb_hit[gi] = (code == TLB_CODES[gi*W_CODE +: W_CODE]);
        end
    endgenerate

    assign is_exc       = (act == ACT_EXC);
    assign is_rst_class = is_exc && (|rst_hit);
    assign is_tlb_class = is_exc && (|tlb_hit);
    assign is_trap      = is_exc && (code == TRAP_CODE);

    always_comb begin
        sr_nx = sr | MODE_SET;
        if (is_rst_class) begin
            sr_nx[BIT_FPDIS]             = 1'b0;
            sr_nx[MASK_LO +: W_MASK]     = '1;
            pc_nx                        = RESET_PC;
        end else if (act == ACT_IRQ) begin
            pc_nx = vbase + OFS_IRQ;
        end else if (is_tlb_class) begin
            pc_nx = vbase + OFS_TLB;
        end else begin
            pc_nx = vbase + OFS_GEN;
        end

        spc_nx = pc;
        if (dslot) begin
            spc_nx = spc_nx - SLOT_STEP;
        end
        if (is_trap) begin
            spc_nx = spc_nx + SLOT_STEP;
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter logic [W_CODE-1:0] UNBLOCKED_CODE = 12'h1E0,
    parameter logic [W_CODE-1:0] TRAP_CODE      = 12'h160,
    parameter logic [W_DATA-1:0] RESET_PC       = 32'hA000_0000,
    parameter logic [W_DATA-1:0] OFS_GEN        = 32'h0000_0100,
    parameter logic [W_DATA-1:0] OFS_TLB        = 32'h0000_0400,
    parameter logic [W_DATA-1:0] OFS_IRQ        = 32'h0000_0600,
    parameter logic [W_DATA-1:0] SLOT_STEP      = 32'd2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_valid,
    input  logic [W_CODE-1:0] exc_code,
    input  logic              irq_req,
    output logic [W_MASK-1:0] ic_level_o,
    input  logic              ic_vec_valid,
    input  logic [W_CODE-1:0] ic_vec,
    input  logic [W_DATA-1:0] sr_i,
    input  logic [W_DATA-1:0] pc_i,
    input  logic [W_DATA-1:0] r15_i,
    input  logic [W_DATA-1:0] vbase_i,
    input  logic              dslot_i,
    input  logic              sleep_i,
    output logic              done_o,
    output logic              rst_req_o,
    output logic [W_DATA-1:0] sr_o,
    output logic [W_DATA-1:0] pc_o,
    output logic [W_DATA-1:0] saved_sr_o,
    output logic [W_DATA-1:0] saved_pc_o,
    output logic [W_DATA-1:0] saved_sp_o,
    output logic [W_CODE-1:0] exc_cause_o,
    output logic [W_CODE-1:0] irq_cause_o,
    output logic              lock_inval_o,
    output logic              dslot_clr_o,
    output logic              sleep_clr_o
);
    entry_state_t      st_d;
    entry_state_t      st_q;
    act_e              act;
    logic [W_DATA-1:0] sr_nx;
    logic [W_DATA-1:0] pc_nx;
    logic [W_DATA-1:0] spc_nx;

    assign ic_level_o = sr_i[MASK_LO +: W_MASK];

    exc_arbiter #(
        .UNBLOCKED_CODE (UNBLOCKED_CODE)
    ) u_arb (
        .exc_valid    (exc_valid),
        .exc_code     (exc_code),
        .irq_req      (irq_req),
        .ic_vec_valid (ic_vec_valid),
        .blocked      (sr_i[BIT_BLOCK]),
        .sleeping     (sleep_i),
        .in_dslot     (dslot_i),
        .act          (act)
    );

    exc_target #(
        .TRAP_CODE (TRAP_CODE),
        .RESET_PC  (RESET_PC),
        .OFS_GEN   (OFS_GEN),
        .OFS_TLB   (OFS_TLB),
        .OFS_IRQ   (OFS_IRQ),
        .SLOT_STEP (SLOT_STEP)
    ) u_tgt (
        .act    (act),
        .code   (exc_code),
        .sr     (sr_i),
        .pc     (pc_i),
        .vbase  (vbase_i),
        .dslot  (dslot_i),
        .sr_nx  (sr_nx),
        .pc_nx  (pc_nx),
        .spc_nx (spc_nx)
    );

    always_comb begin
        st_d            = st_q;
        st_d.done       = 1'b0;
        st_d.rst_req    = 1'b0;
        st_d.lock_inval = 1'b0;
        st_d.dslot_clr  = 1'b0;
        st_d.sleep_clr  = 1'b0;
        case (act)
            ACT_RESET: begin
                st_d.rst_req = 1'b1;
            end
            ACT_EXC, ACT_IRQ: begin
                st_d.saved_sr   = sr_i;
                st_d.saved_pc   = spc_nx;
                st_d.saved_sp   = r15_i;
                st_d.sr         = sr_nx;
                st_d.pc         = pc_nx;
                st_d.done       = 1'b1;
                st_d.lock_inval = 1'b1;
                st_d.sleep_clr  = 1'b1;
                st_d.dslot_clr  = dslot_i;
                if (act == ACT_EXC) begin
                    st_d.exc_cause = exc_code;
                end else begin
                    st_d.irq_cause = ic_vec;
                end
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o       = st_q.done;
    assign rst_req_o    = st_q.rst_req;
    assign sr_o         = st_q.sr;
    assign pc_o         = st_q.pc;
    assign saved_sr_o   = st_q.saved_sr;
    assign saved_pc_o   = st_q.saved_pc;
    assign saved_sp_o   = st_q.saved_sp;
    assign exc_cause_o  = st_q.exc_cause;
    assign irq_cause_o  = st_q.irq_cause;
    assign lock_inval_o = st_q.lock_inval;
    assign dslot_clr_o  = st_q.dslot_clr;
    assign sleep_clr_o  = st_q.sleep_clr;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              exc_valid,
    input logic [W_CODE-1:0] exc_code,
    input logic              irq_req,
    input logic              ic_vec_valid,
    input logic [W_DATA-1:0] sr_i,
    input logic              dslot_i,
    input logic              sleep_i,
    input logic              done_o,
    input logic              rst_req_o,
    input logic [W_DATA-1:0] sr_o,
    input logic [W_DATA-1:0] saved_sr_o,
    input logic [W_CODE-1:0] exc_cause_o
);
    logic blk;
    assign blk = sr_i[BIT_BLOCK];

    p_mode_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (sr_o[BIT_BLOCK] && sr_o[BIT_BANK] && sr_o[BIT_PRIV]));

    p_reset_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> !done_o);

    p_blocked_exc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && blk && exc_code != 12'h1E0) |=>
            (rst_req_o && $stable(saved_sr_o) && $stable(exc_cause_o)));

    p_exc_taken_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && !blk) |=> (done_o && exc_cause_o == $past(exc_code)));

    p_exempt_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && blk && exc_code == 12'h1E0) |=> (done_o && !rst_req_o));

    p_blocked_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_valid && blk && !sleep_i) |=> !done_o);

    p_no_vector_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_valid && !ic_vec_valid) |=> !done_o);

    p_dslot_irq_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_valid && dslot_i) |=> (!done_o && !rst_req_o));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .exc_valid    (exc_valid),
    .exc_code     (exc_code),
    .irq_req      (irq_req),
    .ic_vec_valid (ic_vec_valid),
    .sr_i         (sr_i),
    .dslot_i      (dslot_i),
    .sleep_i      (sleep_i),
    .done_o       (done_o),
    .rst_req_o    (rst_req_o),
    .sr_o         (sr_o),
    .saved_sr_o   (saved_sr_o),
    .exc_cause_o  (exc_cause_o)
);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_valid = 1'b0;
    logic [11:0] exc_code = '0;
    logic        irq_req = 1'b0;
    logic [3:0]  ic_level_o;
    logic        ic_vec_valid = 1'b0;
    logic [11:0] ic_vec = '0;
    logic [31:0] sr_i = '0, pc_i = '0, r15_i = '0, vbase_i = '0;
    logic        dslot_i = 1'b0, sleep_i = 1'b0;
    logic        done_o, rst_req_o, lock_inval_o, dslot_clr_o, sleep_clr_o;
    logic [31:0] sr_o, pc_o, saved_sr_o, saved_pc_o, saved_sp_o;
    logic [11:0] exc_cause_o, irq_cause_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    localparam logic [31:0] VB   = 32'h8C00_0000;
    localparam logic [31:0] MODE = 32'h7000_0000;
    localparam logic [31:0] BLK  = 32'h1000_0000;

    always #10 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .exc_valid(exc_valid), .exc_code(exc_code),
        .irq_req(irq_req), .ic_level_o(ic_level_o), .ic_vec_valid(ic_vec_valid),
        .ic_vec(ic_vec), .sr_i(sr_i), .pc_i(pc_i), .r15_i(r15_i), .vbase_i(vbase_i),
        .dslot_i(dslot_i), .sleep_i(sleep_i), .done_o(done_o), .rst_req_o(rst_req_o),
        .sr_o(sr_o), .pc_o(pc_o), .saved_sr_o(saved_sr_o), .saved_pc_o(saved_pc_o),
        .saved_sp_o(saved_sp_o), .exc_cause_o(exc_cause_o), .irq_cause_o(irq_cause_o),
        .lock_inval_o(lock_inval_o), .dslot_clr_o(dslot_clr_o), .sleep_clr_o(sleep_clr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // inputs set at a falling edge; one rising edge captures; check at next falling edge
    task automatic step_and_clear();
        @(negedge clk);
        exc_valid = 1'b0;
        irq_req   = 1'b0;
        ic_vec_valid = 1'b0;
    endtask

    task automatic setup(input logic [31:0] sr, input logic [31:0] pc,
                         input logic ds, input logic slp);
        sr_i = sr; pc_i = pc; dslot_i = ds; sleep_i = slp;
        r15_i = 32'h0C00_7FF0; vbase_i = VB;
    endtask

    task automatic t_reset_state();
        chk("R12 reset done", {31'd0, done_o}, 32'd0);
        chk("R12 reset pc", pc_o, 32'd0);
        chk("R2 reset req", {31'd0, rst_req_o}, 32'd0);
    endtask

    task automatic t_plain_exc();
        setup(32'h0000_8030, 32'h0000_1000, 1'b0, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h0A0;
        step_and_clear();
        chk("R12 done", {31'd0, done_o}, 32'd1);
        chk("R6 saved sr", saved_sr_o, 32'h0000_8030);
        chk("R6 saved pc", saved_pc_o, 32'h0000_1000);
        chk("R6 saved sp", saved_sp_o, 32'h0C00_7FF0);
        chk("R6 new sr", sr_o, 32'h7000_8030);
        chk("R6 lock", {31'd0, lock_inval_o}, 32'd1);
        chk("R9 general vector", pc_o, VB + 32'h100);
        chk("R11 exc cause", {20'd0, exc_cause_o}, 32'h0A0);
        chk("R4 sleep clr", {31'd0, sleep_clr_o}, 32'd1);
        @(negedge clk);
        chk("R12 single pulse", {31'd0, done_o}, 32'd0);
        chk("R6 lock pulse", {31'd0, lock_inval_o}, 32'd0);
    endtask

    task automatic t_tlb();
        for (int i = 0; i < 2; i++) begin
            setup(32'h0, 32'h0000_2000, 1'b0, 1'b0);
            exc_valid = 1'b1; exc_code = (i == 0) ? 12'h040 : 12'h060;
            step_and_clear();
            chk("R9 tlb vector", pc_o, VB + 32'h400);
        end
    endtask

    task automatic t_rst_class();
        logic [11:0] codes [3] = '{12'h000, 12'h020, 12'h140};
        for (int i = 0; i < 3; i++) begin
            setup(32'h0000_8030, 32'h0000_3000, 1'b0, 1'b0);
            exc_valid = 1'b1; exc_code = codes[i];
            step_and_clear();
            chk("R8 restart pc", pc_o, 32'hA000_0000);
            chk("R8 sr fpu/mask", sr_o, 32'h7000_00F0);
        end
    endtask

    task automatic t_trap_dslot();
        setup(32'h0, 32'h0000_4000, 1'b0, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h160;
        step_and_clear();
        chk("R10 trap spc", saved_pc_o, 32'h0000_4002);
        chk("R10 trap vector", pc_o, VB + 32'h100);
        chk("R7 no dslot clr", {31'd0, dslot_clr_o}, 32'd0);
        setup(32'h0, 32'h0000_5000, 1'b1, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h0E0;
        step_and_clear();
        chk("R7 dslot spc", saved_pc_o, 32'h0000_4FFE);
        chk("R7 dslot clr", {31'd0, dslot_clr_o}, 32'd1);
        chk("R13 exc in dslot", {31'd0, done_o}, 32'd1);
        setup(32'h0, 32'h0000_6000, 1'b1, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h160;
        step_and_clear();
        chk("R10 trap in dslot", saved_pc_o, 32'h0000_6000);
    endtask

    task automatic t_irq();
        setup(32'h0000_0050, 32'h0000_7000, 1'b0, 1'b0);
        #1;
        chk("R5 level", {28'd0, ic_level_o}, 32'd5);
        irq_req = 1'b1; ic_vec_valid = 1'b1; ic_vec = 12'h320;
        step_and_clear();
        chk("R11 irq cause", {20'd0, irq_cause_o}, 32'h320);
        chk("R11 irq vector", pc_o, VB + 32'h600);
        chk("R6 irq saved pc", saved_pc_o, 32'h0000_7000);
        // controller reports no vector
        setup(32'h0000_00A0, 32'h0000_7100, 1'b0, 1'b0);
        #1;
        chk("R5 level2", {28'd0, ic_level_o}, 32'd10);
        irq_req = 1'b1; ic_vec_valid = 1'b0; ic_vec = 12'h3C0;
        step_and_clear();
        chk("R5 none no done", {31'd0, done_o}, 32'd0);
        chk("R5 none pc kept", pc_o, VB + 32'h600);
        chk("R5 none cause kept", {20'd0, irq_cause_o}, 32'h320);
    endtask

    task automatic t_priority();
        setup(32'h0, 32'h0000_8000, 1'b0, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h180;
        irq_req = 1'b1; ic_vec_valid = 1'b1; ic_vec = 12'h400;
        step_and_clear();
        chk("R1 exc cause", {20'd0, exc_cause_o}, 32'h180);
        chk("R1 irq cause kept", {20'd0, irq_cause_o}, 32'h320);
        chk("R1 exc vector", pc_o, VB + 32'h100);
    endtask

    task automatic t_blocked();
        setup(BLK, 32'h0000_9000, 1'b0, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h0A0;
        step_and_clear();
        chk("R2 reset req", {31'd0, rst_req_o}, 32'd1);
        chk("R2 no done", {31'd0, done_o}, 32'd0);
        chk("R2 saved pc kept", saved_pc_o, 32'h0000_8000);
        chk("R2 cause kept", {20'd0, exc_cause_o}, 32'h180);
        @(negedge clk);
        chk("R2 req pulse", {31'd0, rst_req_o}, 32'd0);
        setup(BLK, 32'h0000_9100, 1'b0, 1'b0);
        exc_valid = 1'b1; exc_code = 12'h1E0;
        step_and_clear();
        chk("R3 exempt taken", {31'd0, done_o}, 32'd1);
        chk("R3 exempt no req", {31'd0, rst_req_o}, 32'd0);
        chk("R3 exempt vector", pc_o, VB + 32'h100);
        chk("R3 exempt sr", sr_o, MODE);
    endtask

    task automatic t_blocked_irq();
        setup(BLK, 32'h0000_A000, 1'b0, 1'b0);
        irq_req = 1'b1; ic_vec_valid = 1'b1; ic_vec = 12'h200;
        step_and_clear();
        chk("R4 blocked irq ignored", {31'd0, done_o}, 32'd0);
        chk("R4 cause kept", {20'd0, irq_cause_o}, 32'h320);
        setup(BLK, 32'h0000_A100, 1'b0, 1'b1);
        irq_req = 1'b1; ic_vec_valid = 1'b1; ic_vec = 12'h220;
        step_and_clear();
        chk("R4 sleeping irq taken", {31'd0, done_o}, 32'd1);
        chk("R4 sleep clr", {31'd0, sleep_clr_o}, 32'd1);
        chk("R4 cause", {20'd0, irq_cause_o}, 32'h220);
    endtask

    task automatic t_dslot_irq();
        setup(32'h0, 32'h0000_B000, 1'b1, 1'b0);
        irq_req = 1'b1; ic_vec_valid = 1'b1; ic_vec = 12'h240;
        step_and_clear();
        chk("R13 irq in dslot ignored", {31'd0, done_o}, 32'd0);
        chk("R13 saved pc kept", saved_pc_o, 32'h0000_A100);
        chk("R13 dslot clr off", {31'd0, dslot_clr_o}, 32'd0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain_exc();
        t_tlb();
        t_rst_class();
        t_trap_dslot();
        t_irq();
        t_priority();
        t_blocked();
        t_blocked_irq();
        t_dslot_irq();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule